// File: doc/BRIEF.md
# Packed Control-Word Register Target

This block is the command layer of a serial register target whose register space is a bank of 4-bit control words stored two per byte. A framing layer in front of it delivers received bytes together with strobes for frame start and frame stop, plus a strobe each time the host clocks out a byte. The block parses each host frame, applies 8-, 16- or 32-bit writes to the packed bytes when the frame closes, and for read commands latches an aligned 32-bit block. That block is returned as a six-byte response: a length byte, a status byte and four data bytes.

Write data and read data both travel with the most significant byte first, which means the byte at the highest address goes out first. One control word is a command slot. Any code written to it other than all ones produces a one-cycle command strobe. The all-ones code is a no-op, so a write aimed at the word that shares its byte leaves the slot alone. One configured code also returns the whole bank to its reset contents. A frame whose header is wrong is discarded, and the status byte then reports an abort.

Top module: `cwr_target`

## Requirements
- R1: A frame is laid out as: command byte, count byte, one ignored byte, one ignored byte, address high, address low, then the data. In the command byte, bits 3:2 give the operation (00 read 32, 01 write 8, 10 write 16, 11 write 32). Bits 7, 6 and 1 must all be set. An 8-bit write stores its single data byte at the given address.
- R2: A 16-bit write ignores address bit 0. The first data byte goes to base+1 and the second to base.
- R3: A 32-bit write ignores address bits 1:0. Its four data bytes go to base+3, base+2, base+1 and base, in that order.
- R4: After a read command at address A, the response bytes are 0x05, then status 0x01, then the bytes at B+3, B+2, B+1 and B, where B is A with bits 1:0 cleared. Each read strobe yields exactly one byte with its valid flag, one cycle later.
- R5: Once the six response bytes have been read, further read strobes return 0xFF. Every frame start rewinds the response to its first byte.
- R6: A frame of zero or one byte changes no register and no latched response. This is the host re-sending the command byte before it reads.
- R7: A frame is discarded without changing any register if its count is not 4 plus the data size, if its length does not match that count, or if bit 7, 6 or 1 of its command is clear. The next response then carries status 0x10.
- R8: When command bit 4 is set, one extra trailing byte is expected. That byte is excluded from the count and ignored.
- R9: A read whose address is at or beyond the bank size responds with status 0x10 and zero data. A write whose aligned span does not fit in the bank changes nothing.
- R10: The command slot (control word 6, the low nibble of byte 3) always reads 0xF. Writing 0xF to it does nothing. Writing any other code raises the command strobe for one cycle, with that code on the code output, one cycle after the frame stop. Code 0x0 also returns every byte to its reset value.
- R11: After reset, every byte reads 0x00 except the command slot nibble, and the response is 0x05, 0x10, then four zero bytes. Register contents change only at the clock edge that samples frame stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start_i | input | 1 | Frame start strobe |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_stop_i | input | 1 | Frame stop strobe |
| rd_req_i | input | 1 | Host requests next response byte |
| cw_o | output | 8*NBYTES | Packed control-word bank, byte i at bits 8i+7:8i |
| cmd_pulse_o | output | 1 | Command slot written with a non-no-op code |
| cmd_code_o | output | 4 | Code written to the command slot |
| tx_valid_o | output | 1 | Response byte valid |
| tx_data_o | output | 8 | Response byte |

## Verification
The bench goes after byte ordering: it writes 16- and 32-bit values at unaligned addresses and reads them back from an unaligned address. A design that reverses the order, or that honours the low address bits, puts data in the wrong bytes. It also sends frames with a wrong count, a trailing check byte and a missing end flag. A design that tolerates these corrupts the bank or reports success where it should report an abort. Finally, it writes the neighbour of the command slot with the no-op code, writes the slot with a real code, and writes the clear code. A design that treats the no-op as a command fires a spurious strobe, and one that mishandles the clear code leaves stale data in the bank.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    localparam int         HDR_BYTES = 6;
    localparam logic [7:0] ST_OK     = 8'h01;
    localparam logic [7:0] ST_ABORT  = 8'h10;
    localparam logic [7:0] RESP_LEN  = 8'h05;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam logic [3:0] NOP_CODE  = 4'hF;

    // command byte flag positions
    localparam int B_BEGIN = 7;
    localparam int B_END   = 6;
    localparam int B_PEC   = 4;
    localparam int B_BLOCK = 1;

    typedef enum logic [1:0] {
        OP_RD32 = 2'b00,
        OP_WR8  = 2'b01,
        OP_WR16 = 2'b10,
        OP_WR32 = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_PTR,
        EV_GOOD,
        EV_BAD
    } ev_e;

    // data: first received byte in [31:24]
    typedef struct packed {
        ev_e         ev;
        op_e         op;
        logic [15:0] addr;
        logic [31:0] data;
    } commit_t;

    function automatic logic [2:0] op_size(op_e op);
        case (op)
            OP_WR8:  return 3'd1;
            OP_WR16: return 3'd2;
            OP_WR32: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // j-th received data byte
    function automatic logic [7:0] rx_byte(logic [31:0] d, logic [1:0] j);
        case (j)
            2'd0:    return d[31:24];
            2'd1:    return d[23:16];
            2'd2:    return d[15:8];
            default: return d[7:0];
        endcase
    endfunction

endpackage

// File: rtl/cwr_frame_rx.sv
module cwr_frame_rx
    import cwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_start_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_stop_i,
    output commit_t    commit_o
);

    localparam logic [3:0] NRX_MAX = 4'hF;

    logic        in_frame;
    logic [3:0]  nrx;
    logic [7:0]  cmd_q, cnt_q, ahi_q, alo_q;
    logic [31:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            nrx      <= '0;
            cmd_q    <= '0;
            cnt_q    <= '0;
            ahi_q    <= '0;
            alo_q    <= '0;
            dat_q    <= '0;
        end else if (rx_start_i) begin
            in_frame <= 1'b1;
            nrx      <= '0;
            dat_q    <= '0;
        end else if (rx_stop_i) begin
            in_frame <= 1'b0;
        end else if (rx_valid_i && in_frame) begin
            if (nrx != NRX_MAX) nrx <= nrx + 4'd1;
            case (nrx)
                4'd0: cmd_q <= rx_data_i;
                4'd1: cnt_q <= rx_data_i;
                4'd4: ahi_q <= rx_data_i;
                4'd5: alo_q <= rx_data_i;
                4'd6: dat_q[31:24] <= rx_data_i;
                4'd7: dat_q[23:16] <= rx_data_i;
                4'd8: dat_q[15:8]  <= rx_data_i;
                4'd9: dat_q[7:0]   <= rx_data_i;
                default: ;
            endcase
        end
    end

    op_e        op;
    logic [2:0] sz;
    logic       flags_ok, cnt_ok, len_ok;

    always_comb begin
        op       = op_e'(cmd_q[3:2]);
        sz       = op_size(op);
        flags_ok = cmd_q[B_BEGIN] & cmd_q[B_END] & cmd_q[B_BLOCK];
        cnt_ok   = (cnt_q == (8'd4 + {5'b0, sz}));
        len_ok   = (nrx == (4'(HDR_BYTES) + {1'b0, sz} + {3'b0, cmd_q[B_PEC]}));
        commit_o.ev   = EV_NONE;
        commit_o.op   = op;
        commit_o.addr = {ahi_q, alo_q};
        commit_o.data = dat_q;
        if (rx_stop_i && in_frame && !rx_start_i) begin
            if (nrx <= 4'd1)                       commit_o.ev = EV_PTR;
            else if (flags_ok && cnt_ok && len_ok) commit_o.ev = EV_GOOD;
            else                                   commit_o.ev = EV_BAD;
        end
    end

endmodule

// File: rtl/cwr_reg_array.sv
module cwr_reg_array
    import cwr_pkg::*;
#(
    parameter int         NBYTES   = 16,
    parameter int         CMD_WORD = 6,
    parameter logic [3:0] CLR_CODE = 4'h0
) (
    input  logic                clk,
    input  logic                rst,
    input  commit_t             commit_i,
    output logic [8*NBYTES-1:0] cw_o,
    output logic [31:0]         rd_block_o,
    output logic                rd_ok_o,
    output logic                cmd_pulse_o,
    output logic [3:0]          cmd_code_o
);

    localparam int CMD_BYTE = CMD_WORD / 2;
    localparam int NIB_LSB  = 4 * (CMD_WORD % 2);
    localparam int NBLK     = NBYTES / 4;
    localparam int BW       = (NBLK > 1) ? $clog2(NBLK) : 1;

    logic [2:0]  sz;
    logic [15:0] base;
    logic [16:0] span_end;
    logic        wr_en;

    always_comb begin
        sz       = op_size(commit_i.op);
        base     = commit_i.addr & ~(16'(sz) - 16'd1);
        span_end = {1'b0, base} + 17'(sz);
        wr_en    = (commit_i.ev == EV_GOOD) && (commit_i.op != OP_RD32)
                   && (span_end <= 17'(NBYTES));
    end

    logic [NBYTES-1:0] hit;
    logic [7:0]        wbyte [NBYTES];

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_byte
            localparam logic [7:0] KEEP = (gi == CMD_BYTE) ? 8'(8'h0F << NIB_LSB) : 8'h00;
            logic [15:0] off;
            logic [2:0]  jj;
            logic [7:0]  byte_q;

            always_comb begin
                off       = 16'(gi) - base;
                jj        = sz - 3'd1 - off[2:0];
                hit[gi]   = wr_en && (16'(gi) >= base) && (17'(gi) < span_end);
                wbyte[gi] = rx_byte(commit_i.data, jj[1:0]);
            end

            always_ff @(posedge clk) begin
                if (rst || clr_now) byte_q <= KEEP;
                else if (hit[gi])   byte_q <= wbyte[gi] | KEEP;
            end

            assign cw_o[8*gi +: 8] = byte_q;
        end
    endgenerate

    logic [3:0] cmd_new;
    logic       fire;
    logic       clr_now;

    always_comb begin
        cmd_new = wbyte[CMD_BYTE][NIB_LSB +: 4];
        fire    = hit[CMD_BYTE] && (cmd_new != NOP_CODE);
        clr_now = fire && (cmd_new == CLR_CODE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_pulse_o <= 1'b0;
            cmd_code_o  <= NOP_CODE;
        end else begin
            cmd_pulse_o <= fire;
            if (fire) cmd_code_o <= cmd_new;
        end
    end

    logic [BW-1:0] blk;

    always_comb begin
        blk        = commit_i.addr[BW+1:2];
        rd_ok_o    = commit_i.addr < 16'(NBYTES);
        rd_block_o = cw_o[32*blk +: 32];
    end

endmodule

// File: rtl/cwr_resp_tx.sv
module cwr_resp_tx
    import cwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  commit_t     commit_i,
    input  logic        rd_ok_i,
    input  logic [31:0] rd_block_i,
    input  logic        rx_start_i,
    input  logic        rd_req_i,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o
);

    localparam logic [2:0] PTR_END = 3'd6;

    logic [7:0]  status_q;
    logic [31:0] data_q;
    logic [2:0]  ptr_q;
    logic [7:0]  cur;

    always_comb begin
        case (ptr_q)
            3'd0:    cur = RESP_LEN;
            3'd1:    cur = status_q;
            3'd2:    cur = data_q[31:24];
            3'd3:    cur = data_q[23:16];
            3'd4:    cur = data_q[15:8];
            3'd5:    cur = data_q[7:0];
            default: cur = IDLE_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q   <= ST_ABORT;
            data_q     <= '0;
            ptr_q      <= '0;
            tx_valid_o <= 1'b0;
            tx_data_o  <= '0;
        end else begin
            tx_valid_o <= rd_req_i;
            if (rd_req_i) tx_data_o <= cur;
            if (rx_start_i)                        ptr_q <= '0;
            else if (rd_req_i && ptr_q != PTR_END) ptr_q <= ptr_q + 3'd1;
            if (commit_i.ev == EV_BAD) begin
                status_q <= ST_ABORT;
            end else if (commit_i.ev == EV_GOOD && commit_i.op == OP_RD32) begin
                status_q <= rd_ok_i ? ST_OK : ST_ABORT;
                data_q   <= rd_ok_i ? rd_block_i : 32'h0;
            end
        end
    end

endmodule

// File: rtl/cwr_target.sv
module cwr_target
    import cwr_pkg::*;
#(
    parameter int         NBYTES   = 16,
    parameter int         CMD_WORD = 6,
    parameter logic [3:0] CLR_CODE = 4'h0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_start_i,
    input  logic                rx_valid_i,
    input  logic [7:0]          rx_data_i,
    input  logic                rx_stop_i,
    input  logic                rd_req_i,
    output logic [8*NBYTES-1:0] cw_o,
    output logic                cmd_pulse_o,
    output logic [3:0]          cmd_code_o,
    output logic                tx_valid_o,
    output logic [7:0]          tx_data_o
);

    commit_t     commit;
    logic [31:0] rd_block;
    logic        rd_ok;

    cwr_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_start_i (rx_start_i),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .rx_stop_i  (rx_stop_i),
        .commit_o   (commit)
    );

    cwr_reg_array #(
        .NBYTES   (NBYTES),
        .CMD_WORD (CMD_WORD),
        .CLR_CODE (CLR_CODE)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .cw_o        (cw_o),
        .rd_block_o  (rd_block),
        .rd_ok_o     (rd_ok),
        .cmd_pulse_o (cmd_pulse_o),
        .cmd_code_o  (cmd_code_o)
    );

    cwr_resp_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .commit_i   (commit),
        .rd_ok_i    (rd_ok),
        .rd_block_i (rd_block),
        .rx_start_i (rx_start_i),
        .rd_req_i   (rd_req_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o)
    );

endmodule

// File: rtl/cwr_target_chk.sv
module cwr_target_chk #(
    parameter int NBYTES   = 16,
    parameter int CMD_WORD = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                rx_stop_i,
    input logic                rd_req_i,
    input logic [8*NBYTES-1:0] cw_o,
    input logic                cmd_pulse_o,
    input logic [3:0]          cmd_code_o,
    input logic                tx_valid_o
);

    localparam int SLOT_LSB = 8 * (CMD_WORD / 2) + 4 * (CMD_WORD % 2);

    p_tx_after_req_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> tx_valid_o);

    p_tx_only_req_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> $past(rd_req_i));

    p_bank_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rx_stop_i |=> $stable(cw_o));

    p_slot_reads_nop_r10: assert property (@(posedge clk) disable iff (rst)
        cw_o[SLOT_LSB +: 4] == 4'hF);

    p_pulse_code_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse_o |-> (cmd_code_o != 4'hF));

    p_pulse_after_stop_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse_o |-> $past(rx_stop_i));

endmodule

bind cwr_target cwr_target_chk #(
    .NBYTES   (NBYTES),
    .CMD_WORD (CMD_WORD)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rx_stop_i   (rx_stop_i),
    .rd_req_i    (rd_req_i),
    .cw_o        (cw_o),
    .cmd_pulse_o (cmd_pulse_o),
    .cmd_code_o  (cmd_code_o),
    .tx_valid_o  (tx_valid_o)
);

// File: tb/cwr_target_tb_top.sv
`timescale 1ns/1ps
module cwr_target_tb_top;

    localparam int NB   = 16;
    localparam int SLOT = 3;   // byte holding control word 6 (low nibble)

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_start = 0, rx_valid = 0, rx_stop = 0, rd_req = 0;
    logic [7:0]    rx_data = 0;
    logic [8*NB-1:0] cw;
    logic          cmd_pulse;
    logic [3:0]    cmd_code;
    logic          tx_valid;
    logic [7:0]    tx_data;

    always #2 clk = ~clk;   // 250 MHz

    cwr_target #(.NBYTES(NB), .CMD_WORD(6), .CLR_CODE(4'h0)) dut_i (
        .clk(clk), .rst(rst), .rx_start_i(rx_start), .rx_valid_i(rx_valid),
        .rx_data_i(rx_data), .rx_stop_i(rx_stop), .rd_req_i(rd_req),
        .cw_o(cw), .cmd_pulse_o(cmd_pulse), .cmd_code_o(cmd_code),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural model
    int m [NB];
    int stat;
    int rdb [4];
    bit exp_pulse;
    int exp_code;
    logic [7:0] fq [$];

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NB; i++) m[i] = 0;
        m[SLOT] = 8'h0F;
    endfunction

    function automatic void model_commit();
        int n, cmd, op, s, pec, a, base, nib;
        bit ok;
        n = fq.size();
        exp_pulse = 0;
        if (n <= 1) return;
        cmd = fq[0];
        op  = (cmd >> 2) & 3;
        s   = (op == 0) ? 0 : (op == 1) ? 1 : (op == 2) ? 2 : 4;
        pec = (cmd >> 4) & 1;
        ok  = ((cmd & 8'hC2) == 8'hC2) && (int'(fq[1]) == 4 + s) && (n == 2 + int'(fq[1]) + pec);
        if (!ok) begin stat = 8'h10; return; end
        a = int'(fq[4]) * 256 + int'(fq[5]);
        if (op == 0) begin
            if (a < NB) begin
                base = a - (a % 4);
                stat = 1;
                for (int k = 0; k < 4; k++) rdb[k] = m[base + 3 - k];
            end else begin
                stat = 8'h10;
                for (int k = 0; k < 4; k++) rdb[k] = 0;
            end
        end else begin
            base = a - (a % s);
            if (base + s <= NB) begin
                for (int k = 0; k < s; k++) m[base + s - 1 - k] = fq[6 + k];
                if (base <= SLOT && SLOT < base + s) begin
                    nib = m[SLOT] & 15;
                    if (nib != 15) begin
                        exp_pulse = 1;
                        exp_code  = nib;
                    end
                    if (nib == 0) model_reset();
                    else m[SLOT] = m[SLOT] | 15;
                end
            end
        end
    endfunction

    // compare bank to model every clock (R11)
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            for (int i = 0; i < NB; i++)
                if (int'(cw[8*i +: 8]) != m[i]) begin
                    fails++;
                    $display("FAIL R11 byte %0d: actual 0x%0h expected 0x%0h", i, cw[8*i +: 8], m[i]);
                end
            tests++;
        end
    end

    task automatic send_frame(string req);
        @(negedge clk) rx_start = 1;
        @(negedge clk) rx_start = 0;
        foreach (fq[i]) begin
            rx_valid = 1; rx_data = fq[i];
            @(negedge clk);
        end
        rx_valid = 0;
        rx_stop  = 1;
        model_commit();
        @(posedge clk);
        #1;
        check({req, " R10 pulse"}, int'(cmd_pulse), int'(exp_pulse));
        if (exp_pulse) check({req, " R10 code"}, int'(cmd_code), exp_code);
        @(negedge clk) rx_stop = 0;
    endtask

    task automatic read_byte(string req, int exp);
        @(negedge clk) rd_req = 1;
        @(posedge clk);
        #1;
        check({req, " valid"}, int'(tx_valid), 1);
        check(req, int'(tx_data), exp);
        @(negedge clk) rd_req = 0;
    endtask

    task automatic read_resp(string req);
        fq = '{8'hC2};
        send_frame({req, " R6 ptr"});
        read_byte({req, " R4 len"}, 5);
        read_byte({req, " R4 status"}, stat);
        for (int k = 0; k < 4; k++) read_byte({req, " R4 data"}, rdb[k]);
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        stat = 8'h10;
        for (int k = 0; k < 4; k++) rdb[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        read_resp("R11 reset");

        // R1 byte write
        fq = '{8'hC6, 8'd5, 8'h00, 8'h00, 8'h00, 8'h05, 8'hA5};
        send_frame("R1");
        // R2 16-bit write, odd address
        fq = '{8'hCA, 8'd6, 8'h00, 8'h00, 8'h00, 8'h09, 8'h12, 8'h34};
        send_frame("R2");
        // R3 32-bit write, unaligned address
        fq = '{8'hCE, 8'd8, 8'h00, 8'h00, 8'h00, 8'h0E, 8'h11, 8'h22, 8'h33, 8'h44};
        send_frame("R3");
        check("R3 byte15", int'(cw[8*15 +: 8]), 8'h11);
        check("R2 byte9", int'(cw[8*9 +: 8]), 8'h12);

        // R4 read unaligned
        fq = '{8'hC2, 8'd4, 8'h00, 8'h00, 8'h00, 8'h0D};
        send_frame("R4");
        read_resp("R4");
        read_byte("R5 past end", 8'hFF);
        fq = '{8'hC2};
        send_frame("R5 rewind");
        read_byte("R5 rewound len", 5);

        // R4 read of block 8
        fq = '{8'hC2, 8'd4, 8'h00, 8'h00, 8'h00, 8'h08};
        send_frame("R4 b8");
        read_resp("R4 b8");

        // R7 bad count
        fq = '{8'hC6, 8'd6, 8'h00, 8'h00, 8'h00, 8'h05, 8'h77};
        send_frame("R7 count");
        read_resp("R7 count");
        // R7 missing end flag
        fq = '{8'h86, 8'd5, 8'h00, 8'h00, 8'h00, 8'h01, 8'h66};
        send_frame("R7 end");
        read_resp("R7 end");
        // R7 too long
        fq = '{8'hC6, 8'd5, 8'h00, 8'h00, 8'h00, 8'h01, 8'h66, 8'h67};
        send_frame("R7 long");
        read_resp("R7 long");

        // R8 PEC byte accepted
        fq = '{8'hD6, 8'd5, 8'h00, 8'h00, 8'h00, 8'h02, 8'h5C, 8'hEE};
        send_frame("R8 wr");
        fq = '{8'hD2, 8'd4, 8'h00, 8'h00, 8'h00, 8'h00, 8'hEE};
        send_frame("R8 rd");
        read_resp("R8");

        // R9 out of range
        fq = '{8'hCE, 8'd8, 8'h00, 8'h00, 8'h00, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04};
        send_frame("R9 wr");
        fq = '{8'hC6, 8'd5, 8'h00, 8'h00, 8'h01, 8'h05, 8'h99};
        send_frame("R9 wr hi");
        fq = '{8'hC2, 8'd4, 8'h00, 8'h00, 8'h00, 8'h10};
        send_frame("R9 rd");
        read_resp("R9");

        // R10 neighbour write with no-op code in slot
        fq = '{8'hC6, 8'd5, 8'h00, 8'h00, 8'h00, 8'h03, 8'hAF};
        send_frame("R10 nop");
        check("R10 nop byte3", int'(cw[8*3 +: 8]), 8'hAF);
        fq = '{8'hC6, 8'd5, 8'h00, 8'h00, 8'h00, 8'h03, 8'h5B};
        send_frame("R10 code");
        check("R10 slot reads F", int'(cw[8*3 +: 8]), 8'h5F);
        // R10 clear code through a 32-bit write
        fq = '{8'hCE, 8'd8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h70, 8'h21, 8'h22, 8'h23};
        send_frame("R10 clear");
        check("R10 cleared byte15", int'(cw[8*15 +: 8]), 0);
        fq = '{8'hC2, 8'd4, 8'h00, 8'h00, 8'h00, 8'h00};
        send_frame("R10 rd");
        read_resp("R10");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule